// File: doc/BRIEF.md
# Handshaked Register Port with Odd-Parity Protection

This block lets a general-purpose microprocessor reach 32 eight-bit registers over an asynchronous bus with a full request/acknowledge handshake. The processor first sets the direction select, the address, the data and its parity bit. It then pulls the active-low chip enable low. The block brings every bus input into its own clock domain through a two-stage synchroniser, waits a fixed settling delay, and then performs the access once. It signals completion by pulling the active-low acknowledge low, and keeps it low until the chip enable is released.

Reads always return an odd-parity bit with the data. On writes, a checker enable input decides whether the incoming parity is checked. A write that fails the check is dropped, and it sets a sticky parity-error flag. That flag sits in an interrupt condition register, together with condition pulses from neighbouring logic. An interrupt enable register gates the conditions onto an active-low interrupt output. The bidirectional data lines are modelled as separate input and output buses plus an output enable. The open-drain outputs are modelled as active-low levels.

Top module: `cbus_regport`

## Requirements
- R1: After reset, ack_n and irq_n are high and data_oe is low. The interrupt enable register (address 1) reads 0xFF, and every other register, including the condition register at address 0, reads 0x00.
- R2: With the default settling delay ACK_DLY=2, ack_n goes low on the (ACK_DLY+3)th rising clock edge after ce_n is first sampled low. It then stays low for as long as ce_n stays low.
- R3: After ce_n returns high, ack_n goes high on the third rising edge. Each low period of ce_n performs exactly one access.
- R4: On a read (rd_wr_n=1), data_out holds the addressed register's content. data_out is enabled (data_oe=1) only while ack_n is low in a read cycle, and stays stable for that whole time. data_oe stays low during write cycles.
- R5: par_out is odd parity over data_out, meaning the count of ones in {data_out, par_out} is odd. This holds whatever the value of par_chk_en or par_in.
- R6: A write stores data_in at the addressed register (addresses 1 to 31) when par_chk_en is low, or when {data_in, par_in} has an odd number of ones.
- R7: A write with par_chk_en high and an even number of ones in {data_in, par_in} leaves every register unchanged. Instead, it sets condition bit 0 at address 0.
- R8: The condition register at address 0 is sticky. A one-cycle high on irq_src[i] sets bit i. A write clears each bit that is written as 1 and leaves each bit written as 0 unchanged.
- R9: irq_n is low exactly when some condition bit is set and its enable bit at address 1 is 1 (1 = enabled). It follows a change of either register by the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Active-low chip enable, starts and ends an access |
| rd_wr_n | input | 1 | 1 = read cycle, 0 = write cycle |
| addr | input | 5 | Register address, bit 4 most significant |
| data_in | input | 8 | Write data from the bus |
| par_in | input | 1 | Odd-parity bit accompanying data_in |
| par_chk_en | input | 1 | Enables the write parity checker |
| irq_src | input | 8 | Condition pulses that set condition register bits |
| data_out | output | 8 | Read data driven onto the bus |
| par_out | output | 1 | Odd-parity bit over data_out |
| data_oe | output | 1 | Output enable for data_out and par_out |
| ack_n | output | 1 | Active-low acknowledge |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The hardest case to reach from the ports is a corrupted write. The register must stay unchanged, and the parity flag and interrupt must still rise. Proving that nothing was stored takes a second, clean handshake that reads the same address back. The bench therefore pairs each bad-parity write with a read of the target and of the condition register. It repeats this with the checker disabled to show the same bad word being stored. A second hard case is holding the chip enable low for many cycles during a read that carries deliberately wrong bus parity. The bench stretches the handshake and samples the output bus on every cycle to show it neither changes nor re-triggers.

// File: rtl/cbus_pkg.sv
package cbus_pkg;

  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_WAIT = 2'd1,
    HS_ACT  = 2'd2
  } hs_state_t;

  localparam int unsigned PERR_BIT = 0;

  function automatic logic odd_par8(input logic [7:0] d);
    return ~(^d);
  endfunction

endpackage

// File: rtl/cbus_sync.sv
module cbus_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  always_comb begin
    stg_d[0] = d;
    for (int i = 1; i < STAGES; i++) begin
      stg_d[i] = stg_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) begin
        stg_q[i] <= RST_VAL;
      end
    end else begin
      stg_q <= stg_d;
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/cbus_hshake.sv
module cbus_hshake
  import cbus_pkg::*;
#(
  parameter int unsigned ACK_DLY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_s_n,
  input  logic rw_s,
  output logic acc_stb,
  output logic ack_n,
  output logic rd_act
);

  localparam int unsigned CW = (ACK_DLY < 2) ? 1 : $clog2(ACK_DLY + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(ACK_DLY - 1);

  hs_state_t st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          rd_q, rd_d;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    rd_d    = rd_q;
    acc_stb = 1'b0;
    unique case (st_q)
      HS_IDLE: begin
        if (!ce_s_n) begin
          st_d  = HS_WAIT;
          cnt_d = CNT_LOAD;
        end
      end
      HS_WAIT: begin
        if (ce_s_n) begin
          st_d = HS_IDLE;
        end else if (cnt_q == '0) begin
          st_d    = HS_ACT;
          acc_stb = 1'b1;
          rd_d    = rw_s;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      HS_ACT: begin
        if (ce_s_n) begin
          st_d = HS_IDLE;
          rd_d = 1'b0;
        end
      end
      default: st_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= HS_IDLE;
      cnt_q <= '0;
      rd_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      rd_q  <= rd_d;
    end
  end

  assign ack_n  = (st_q != HS_ACT);
  assign rd_act = rd_q && (st_q == HS_ACT);

endmodule

// File: rtl/cbus_regbank.sv
module cbus_regbank
  import cbus_pkg::*;
#(
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ICR_ADDR  = 0,
  parameter int unsigned MASK_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_stb,
  input  logic              rw_s,
  input  logic [ADDR_W-1:0] addr_s,
  input  logic [DATA_W-1:0] wdata_s,
  input  logic              par_s,
  input  logic              chk_s,
  input  logic [DATA_W-1:0] irq_src,
  output logic [DATA_W-1:0] rdata_q,
  output logic [DATA_W-1:0] icr_q,
  output logic [DATA_W-1:0] mask_q,
  output logic              irq_n
);

  localparam int unsigned NREG = 1 << ADDR_W;

  logic [NREG-1:0][DATA_W-1:0] regs_q, regs_d;
  logic [DATA_W-1:0]           rdata_d;
  logic                        irq_n_d;
  logic                        par_ok;
  logic                        wr_req;
  logic                        perr_evt;
  logic [DATA_W-1:0]           perr_vec;

  assign par_ok   = ^{wdata_s, par_s};
  assign wr_req   = acc_stb && !rw_s;
  assign perr_evt = wr_req && chk_s && !par_ok;
  assign perr_vec = perr_evt ? (DATA_W'(1) << PERR_BIT) : '0;

  always_comb begin
    regs_d = regs_q;
    if (wr_req && !perr_evt) begin
      if (addr_s == ADDR_W'(ICR_ADDR)) begin
        regs_d[ICR_ADDR] = regs_q[ICR_ADDR] & ~wdata_s;
      end else begin
        regs_d[addr_s] = wdata_s;
      end
    end
    regs_d[ICR_ADDR] = regs_d[ICR_ADDR] | irq_src | perr_vec;
  end

  always_comb begin
    rdata_d = rdata_q;
    if (acc_stb && rw_s) begin
      rdata_d = regs_q[addr_s];
    end
  end

  assign irq_n_d = ~|(regs_d[ICR_ADDR] & regs_d[MASK_ADDR]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        regs_q[i] <= (i == MASK_ADDR) ? {DATA_W{1'b1}} : '0;
      end
      rdata_q <= '0;
      irq_n   <= 1'b1;
    end else begin
      regs_q  <= regs_d;
      rdata_q <= rdata_d;
      irq_n   <= irq_n_d;
    end
  end

  assign icr_q  = regs_q[ICR_ADDR];
  assign mask_q = regs_q[MASK_ADDR];

endmodule

// File: rtl/cbus_regport.sv
module cbus_regport
  import cbus_pkg::*;
#(
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ACK_DLY     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              rd_wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data_in,
  input  logic              par_in,
  input  logic              par_chk_en,
  input  logic [DATA_W-1:0] irq_src,
  output logic [DATA_W-1:0] data_out,
  output logic              par_out,
  output logic              data_oe,
  output logic              ack_n,
  output logic              irq_n
);

  localparam int unsigned BW = 4 + ADDR_W + DATA_W;
  localparam logic [BW-1:0] BUS_IDLE = {1'b1, {(BW-1){1'b0}}};

  logic [BW-1:0]     bus_raw, bus_s;
  logic              ce_s_n, rw_s, chk_s, par_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] wdata_s;
  logic              acc_stb, rd_act;
  logic [DATA_W-1:0] rdata_q, icr_q, mask_q;

  assign bus_raw = {ce_n, rd_wr_n, par_chk_en, par_in, addr, data_in};

  cbus_sync #(
    .W(BW), .STAGES(SYNC_STAGES), .RST_VAL(BUS_IDLE)
  ) u_sync (
    .clk(clk), .rst_n(rst_n), .d(bus_raw), .q(bus_s)
  );

  assign {ce_s_n, rw_s, chk_s, par_s, addr_s, wdata_s} = bus_s;

  cbus_hshake #(.ACK_DLY(ACK_DLY)) u_hs (
    .clk(clk), .rst_n(rst_n), .ce_s_n(ce_s_n), .rw_s(rw_s),
    .acc_stb(acc_stb), .ack_n(ack_n), .rd_act(rd_act)
  );

  cbus_regbank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .acc_stb(acc_stb), .rw_s(rw_s),
    .addr_s(addr_s), .wdata_s(wdata_s), .par_s(par_s), .chk_s(chk_s),
    .irq_src(irq_src), .rdata_q(rdata_q), .icr_q(icr_q),
    .mask_q(mask_q), .irq_n(irq_n)
  );

  assign data_out = rdata_q;
  assign par_out  = ~(^rdata_q);
  assign data_oe  = rd_act && !ack_n;

endmodule

// File: rtl/cbus_regport_chk.sv
module cbus_regport_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              ack_n,
  input logic              data_oe,
  input logic [DATA_W-1:0] data_out,
  input logic              par_out,
  input logic              irq_n,
  input logic [DATA_W-1:0] icr_q,
  input logic [DATA_W-1:0] mask_q
);

  p_ack_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_n && !$past(ce_n, 2)) |=> !ack_n);

  p_ack_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ce_n, 3) |-> ack_n);

  p_oe_in_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> !ack_n);

  p_read_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe && $past(data_oe)) |-> ($stable(data_out) && $stable(par_out)));

  p_odd_parity_r5: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> (^{data_out, par_out}));

  p_irq_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(icr_q & mask_q)) |-> !irq_n);

  p_irq_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(icr_q & mask_q)) |-> irq_n);

endmodule

bind cbus_regport cbus_regport_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .ack_n(ack_n),
  .data_oe(data_oe), .data_out(data_out), .par_out(par_out),
  .irq_n(irq_n), .icr_q(icr_q), .mask_q(mask_q)
);

// File: tb/cbus_regport_test.sv
module cbus_regport_test;

  localparam int ACK_DLY = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ce_n, rd_wr_n, par_in, par_chk_en;
  logic [4:0] addr;
  logic [7:0] data_in, irq_src;
  logic [7:0] data_out;
  logic       par_out, data_oe, ack_n, irq_n;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  cbus_regport #(.ACK_DLY(ACK_DLY)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .rd_wr_n(rd_wr_n),
    .addr(addr), .data_in(data_in), .par_in(par_in),
    .par_chk_en(par_chk_en), .irq_src(irq_src), .data_out(data_out),
    .par_out(par_out), .data_oe(data_oe), .ack_n(ack_n), .irq_n(irq_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic good_par(input logic [7:0] d);
    return ~(^d);
  endfunction

  // one handshake; returns read data (sampled mid-ack) when rd=1
  task automatic access(input bit rd, input logic [4:0] a, input logic [7:0] d,
                        input bit chk, input bit bad, input int hold,
                        output logic [7:0] rdat);
    int n;
    logic [7:0] first;
    @(negedge clk);
    rd_wr_n = rd; addr = a; data_in = d; par_chk_en = chk;
    par_in = bad ? ~good_par(d) : good_par(d);
    @(negedge clk);
    ce_n = 1'b0;
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (ack_n && n < 20);
    check(n == ACK_DLY + 3, "R2 ack latency", n, ACK_DLY + 3);
    check(data_oe == rd, "R4 output enable", data_oe, rd);
    first = data_out;
    if (rd) check(^{data_out, par_out} == 1'b1, "R5 read parity odd", par_out, good_par(data_out));
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      check(!ack_n, "R2 ack held while ce low", ack_n, 0);
      if (rd) check(data_out == first && data_oe, "R4 read data stable", data_out, first);
    end
    rdat = first;
    ce_n = 1'b1;
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (!ack_n && n < 20);
    check(n == 3, "R3 ack release", n, 3);
    check(!data_oe, "R4 oe off after release", data_oe, 0);
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d, input bit chk, input bit bad);
    logic [7:0] dummy;
    access(1'b0, a, d, chk, bad, 0, dummy);
  endtask

  task automatic rd_expect(input logic [4:0] a, input logic [7:0] exp, input string req);
    logic [7:0] r;
    access(1'b1, a, 8'h00, 1'b0, 1'b0, 0, r);
    check(r == exp, req, r, exp);
  endtask

  task automatic t_reset;
    check(ack_n == 1'b1, "R1 ack_n after reset", ack_n, 1);
    check(irq_n == 1'b1, "R1 irq_n after reset", irq_n, 1);
    check(data_oe == 1'b0, "R1 data_oe after reset", data_oe, 0);
    rd_expect(5'd1, 8'hFF, "R1 enable reg reset");
    rd_expect(5'd0, 8'h00, "R1 condition reg reset");
    rd_expect(5'd31, 8'h00, "R1 reg 31 reset");
  endtask

  task automatic t_rw_patterns;
    wr(5'd2, 8'hA5, 1'b1, 1'b0);  rd_expect(5'd2, 8'hA5, "R6 reg2 A5");
    wr(5'd17, 8'h3C, 1'b1, 1'b0); rd_expect(5'd17, 8'h3C, "R6 reg17 3C");
    wr(5'd30, 8'hFF, 1'b0, 1'b0); rd_expect(5'd30, 8'hFF, "R6 reg30 FF");
    wr(5'd31, 8'h01, 1'b1, 1'b0); rd_expect(5'd31, 8'h01, "R6 reg31 01");
    rd_expect(5'd2, 8'hA5, "R6 reg2 kept");
    check(irq_n, "R9 no irq after clean writes", irq_n, 1);
  endtask

  task automatic t_bad_parity;
    wr(5'd5, 8'h77, 1'b1, 1'b1);
    check(!irq_n, "R7 R9 irq after parity error", irq_n, 0);
    rd_expect(5'd5, 8'h00, "R7 bad write dropped");
    rd_expect(5'd0, 8'h01, "R7 parity flag set");
    wr(5'd6, 8'h55, 1'b0, 1'b1);
    rd_expect(5'd6, 8'h55, "R6 checker off stores");
    rd_expect(5'd0, 8'h01, "R6 checker off no new flag");
  endtask

  task automatic t_w1c;
    wr(5'd0, 8'hFE, 1'b1, 1'b0);
    rd_expect(5'd0, 8'h01, "R8 zero bits leave flag");
    check(!irq_n, "R9 irq still low", irq_n, 0);
    wr(5'd0, 8'h01, 1'b1, 1'b0);
    rd_expect(5'd0, 8'h00, "R8 write one clears");
    check(irq_n, "R9 irq released", irq_n, 1);
  endtask

  task automatic t_irq_src;
    wr(5'd1, 8'hF7, 1'b1, 1'b0);
    @(negedge clk); irq_src = 8'h08;
    @(negedge clk); irq_src = 8'h00;
    check(irq_n, "R9 masked condition no irq", irq_n, 1);
    repeat (3) @(negedge clk);
    rd_expect(5'd0, 8'h08, "R8 source sets sticky bit");
    wr(5'd1, 8'hFF, 1'b1, 1'b0);
    check(!irq_n, "R9 enabling asserts irq", irq_n, 0);
    wr(5'd0, 8'h08, 1'b1, 1'b0);
    check(irq_n, "R8 R9 clear drops irq", irq_n, 1);
  endtask

  task automatic t_long_read;
    logic [7:0] r;
    access(1'b1, 5'd17, 8'h00, 1'b1, 1'b1, 20, r);
    check(r == 8'h3C, "R5 read ignores bus parity", r, 8'h3C);
    rd_expect(5'd0, 8'h00, "R3 R5 long read raised no flag");
  endtask

  initial begin
    rst_n = 1'b0; ce_n = 1'b1; rd_wr_n = 1'b1; addr = '0; data_in = '0;
    par_in = 1'b1; par_chk_en = 1'b0; irq_src = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_rw_patterns;
    t_bad_parity;
    t_w1c;
    t_irq_src;
    t_long_read;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule